// File: doc/BRIEF.md
# Host Command and Reply Mailbox

This block is the device-side register window of a storage controller mailbox. The host hands work to the device by writing 32-bit command addresses to a request port. Each write lands in an inbound queue, and the device logic drains that queue through a valid/ready pop interface. In the other direction, the device pushes 32-bit completion tags into an outbound queue through a valid/ready push interface. The host collects them one at a time by reading a reply port, and each such read is destructive.

The host sees an interrupt status word, an interrupt mask with inverted sense (a set bit silences the interrupt), and a scratchpad word that carries a readiness signature. A single interrupt line is raised while completions wait and the mask allows it. Register access is single-cycle: a read returns data in the same cycle it is presented, and any side effect of an access takes place at the closing clock edge.

Top module: `mbox_regs`

## Requirements
- R1: A bus write to offset 0x40 appends the written word to the request queue. The device receives the words in write order on `req_data`, with `req_valid` high, and one word is removed at each clock edge where `req_valid` and `req_ready` are both high.
- R2: A write to offset 0x40 while the request queue holds DEPTH words is discarded and sets status bit 0. That bit stays set until the host writes a value with bit 0 set to offset 0x30.
- R3: A bus read of offset 0x44 returns the oldest reply in the same cycle and removes it from the queue at the closing edge, so replies come out in push order.
- R4: A read of offset 0x44 while the reply queue is empty returns 0xFFFFFFFF and changes no state.
- R5: Status bit 3 (value 0x08) at offset 0x30 is 1 exactly while the reply queue holds at least one entry. All other status bits apart from bit 0 read 0.
- R6: Offset 0x34 holds the mask word. It resets to 0x08, and a read returns the last value written.
- R7: `irq` is high exactly when status bit 3 is 1 and mask bit 3 is 0.
- R8: Offset 0xB0 reads 0xFFFF0000 while `dev_ready` is high and 0 otherwise.
- R9: While the reply queue holds DEPTH entries, `rpl_ready` is low and a push offered on `rpl_valid` is not stored.
- R10: After reset both queues are empty, `req_valid` and `irq` are low, and the status word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| req_valid | output | 1 | Request queue not empty |
| req_ready | input | 1 | Device takes the head request |
| req_data | output | 32 | Head request word |
| rpl_valid | input | 1 | Device offers a reply |
| rpl_ready | output | 1 | Reply queue has room |
| rpl_data | input | 32 | Reply word |
| dev_ready | input | 1 | Device reports itself ready |
| irq | output | 1 | Reply interrupt |

## Verification
Read data is combinational, so a reply-port read and its sentinel are checked in the access cycle itself, one time unit after the inputs are set up and before the edge that pops. A request write, a reply push or a mask write takes effect at the next rising edge. For that reason `req_valid`, `irq`, `rpl_ready` and the status word are sampled at the following falling edge, one register stage after the stimulus. The request monitor compares `req_data` at each falling edge where valid and ready are both high, which is the word consumed at the next rising edge.

// File: rtl/mbox_regs.sv
module mbox_regs #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [DW-1:0] req_data,
  input  logic          rpl_valid,
  output logic          rpl_ready,
  input  logic [DW-1:0] rpl_data,
  input  logic          dev_ready,
  output logic          irq
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [AW-1:0] A_STAT = AW'(8'h30);
  localparam logic [AW-1:0] A_MASK = AW'(8'h34);
  localparam logic [AW-1:0] A_REQ  = AW'(8'h40);
  localparam logic [AW-1:0] A_RPL  = AW'(8'h44);
  localparam logic [AW-1:0] A_SCR  = AW'(8'hB0);

  logic [DW-1:0] req_mem [DEPTH];
  logic [DW-1:0] rpl_mem [DEPTH];
  logic [PW-1:0] req_wp, req_rp, rpl_wp, rpl_rp;
  logic [CW-1:0] req_cnt, rpl_cnt;
  logic [DW-1:0] mask_q;
  logic          ovf_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  wire wr_req  = bus_sel & bus_wr & (bus_addr == A_REQ);
  wire wr_stat = bus_sel & bus_wr & (bus_addr == A_STAT);
  wire wr_mask = bus_sel & bus_wr & (bus_addr == A_MASK);
  wire rd_rpl  = bus_sel & ~bus_wr & (bus_addr == A_RPL);

  wire req_full  = (req_cnt == FULL);
  wire rpl_empty = (rpl_cnt == '0);
  wire req_push  = wr_req & ~req_full;
  wire req_pop   = req_valid & req_ready;
  wire rpl_push  = rpl_valid & rpl_ready;
  wire rpl_pop   = rd_rpl & ~rpl_empty;
  wire pending   = ~rpl_empty;

  assign req_valid = (req_cnt != '0);
  assign req_data  = req_mem[req_rp];
  assign rpl_ready = (rpl_cnt != FULL);
  assign irq       = pending & ~mask_q[3];

  always_ff @(posedge clk) begin
    if (req_push) req_mem[req_wp] <= bus_wdata;
    if (rpl_push) rpl_mem[rpl_wp] <= rpl_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_wp  <= '0;
      req_rp  <= '0;
      req_cnt <= '0;
      rpl_wp  <= '0;
      rpl_rp  <= '0;
      rpl_cnt <= '0;
      mask_q  <= DW'(32'h8);
      ovf_q   <= 1'b0;
    end else begin
      if (req_push) req_wp <= bump(req_wp);
      if (req_pop)  req_rp <= bump(req_rp);
      if (req_push & ~req_pop)      req_cnt <= req_cnt + 1'b1;
      else if (req_pop & ~req_push) req_cnt <= req_cnt - 1'b1;
      if (rpl_push) rpl_wp <= bump(rpl_wp);
      if (rpl_pop)  rpl_rp <= bump(rpl_rp);
      if (rpl_push & ~rpl_pop)      rpl_cnt <= rpl_cnt + 1'b1;
      else if (rpl_pop & ~rpl_push) rpl_cnt <= rpl_cnt - 1'b1;
      if (wr_mask) mask_q <= bus_wdata;
      if (wr_req & req_full)          ovf_q <= 1'b1;
      else if (wr_stat & bus_wdata[0]) ovf_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_STAT:  bus_rdata = DW'({pending, 2'b00, ovf_q});
      A_MASK:  bus_rdata = mask_q;
      A_RPL:   bus_rdata = rpl_empty ? '1 : rpl_mem[rpl_rp];
      A_SCR:   bus_rdata = dev_ready ? DW'(32'hFFFF0000) : '0;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mbox_regs_chk.sv
module mbox_regs_chk #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  parameter int AW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rpl_ready,
  input logic          irq,
  input logic [CW-1:0] req_cnt,
  input logic [CW-1:0] rpl_cnt,
  input logic [DW-1:0] mask_q,
  input logic          ovf_q
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  a_r1_valid_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == AW'(8'h40)) |=> req_valid);

  a_r2_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == AW'(8'h40) && req_cnt == FULL) |=> ovf_q);

  a_r2_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == AW'(8'h40) && req_cnt == FULL && !req_ready) |=> req_cnt == FULL);

  a_r4_sentinel: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == AW'(8'h44) && rpl_cnt == '0) |-> bus_rdata == '1);

  a_r5_irq_needs_reply: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> rpl_cnt != '0);

  a_r6_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == AW'(8'h34)) |=> mask_q == $past(bus_wdata));

  a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q[3] |-> !irq);

  a_r9_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (rpl_cnt == FULL) |-> !rpl_ready);
endmodule

bind mbox_regs mbox_regs_chk #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .req_valid(req_valid), .req_ready(req_ready), .rpl_ready(rpl_ready),
  .irq(irq), .req_cnt(req_cnt), .rpl_cnt(rpl_cnt), .mask_q(mask_q),
  .ovf_q(ovf_q)
);

// File: tb/test_mbox_regs.sv
module test_mbox_regs;
  localparam int DEPTH = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0, req_ready = 0, rpl_valid = 0, dev_ready = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, rpl_data = '0;
  logic [31:0] bus_rdata, req_data;
  logic req_valid, rpl_ready, irq;
  int checks = 0, errors = 0, popped = 0;
  logic [31:0] req_q[$];
  logic [31:0] rpl_q[$];

  always #4 clk = ~clk;

  mbox_regs #(.DEPTH(DEPTH)) i_mbox_regs (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic host_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 chk(tag, bus_rdata, exp);
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic post_req(input logic [31:0] d, input bit expect_kept);
    if (expect_kept) req_q.push_back(d);
    host_write(8'h40, d);
  endtask

  task automatic dev_reply(input logic [31:0] d);
    @(negedge clk);
    if (rpl_ready) rpl_q.push_back(d);
    rpl_valid = 1; rpl_data = d;
    @(negedge clk);
    rpl_valid = 0;
  endtask

  task automatic collect(input string tag);
    logic [31:0] e;
    e = (rpl_q.size() != 0) ? rpl_q.pop_front() : 32'hFFFFFFFF;
    host_read(8'h44, e, tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      popped++;
      if (req_q.size() == 0) chk("R1 unexpected request", req_data, 32'hx);
      else chk("R1 request order", req_data, req_q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R10 req_valid", {31'b0, req_valid}, 0);
    chk("R10 irq", {31'b0, irq}, 0);
    host_read(8'h30, 32'h0, "R10 status");
    host_read(8'h34, 32'h8, "R6 mask reset");
    host_read(8'h44, 32'hFFFFFFFF, "R4 empty read");
    host_read(8'h30, 32'h0, "R4 status unchanged");

    host_read(8'hB0, 32'h0, "R8 not ready");
    dev_ready = 1;
    host_read(8'hB0, 32'hFFFF0000, "R8 ready");

    post_req(32'hA000_0010, 1);
    post_req(32'hA000_0020, 1);
    post_req(32'hA000_0030, 1);
    chk("R1 valid held", {31'b0, req_valid}, 1);
    req_ready = 1;
    while (req_q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk("R1 drained", {31'b0, req_valid}, 0);
    req_ready = 0;

    popped = 0;
    for (int i = 0; i < DEPTH + 2; i++) post_req(32'hB000_0000 + i, i < DEPTH);
    host_read(8'h30, 32'h1, "R2 overflow flag");
    host_write(8'h30, 32'h0);
    host_read(8'h30, 32'h1, "R2 flag sticky");
    host_write(8'h30, 32'h1);
    host_read(8'h30, 32'h0, "R2 flag cleared");
    req_ready = 1;
    while (req_q.size() != 0) @(negedge clk);
    @(negedge clk);
    req_ready = 0;
    chk("R2 kept count", popped, DEPTH);
    chk("R2 nothing extra", {31'b0, req_valid}, 0);

    host_write(8'h34, 32'h0);
    dev_reply(32'hC0DE_0001);
    chk("R7 irq unmasked", {31'b0, irq}, 1);
    host_read(8'h30, 32'h8, "R5 pending");
    host_write(8'h34, 32'h8);
    host_read(8'h34, 32'h8, "R6 readback");
    chk("R7 irq masked", {31'b0, irq}, 0);
    host_write(8'h34, 32'h0);
    dev_reply(32'hC0DE_0002);
    dev_reply(32'hC0DE_0003);
    collect("R3 reply 1");
    collect("R3 reply 2");
    chk("R7 irq still pending", {31'b0, irq}, 1);
    collect("R3 reply 3");
    chk("R5 irq drops when empty", {31'b0, irq}, 0);
    host_read(8'h30, 32'h0, "R5 pending clear");
    collect("R4 sentinel after drain");

    for (int i = 0; i < DEPTH; i++) dev_reply(32'hD000_0000 + i);
    chk("R9 ready low when full", {31'b0, rpl_ready}, 0);
    dev_reply(32'hDEAD_BEEF);
    for (int i = 0; i < DEPTH; i++) collect("R9 full queue order");
    collect("R9 rejected push absent");
    chk("R9 ready back", {31'b0, rpl_ready}, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule